// File: doc/BRIEF.md
# Per-Target Interrupt Priority Selector

This block serves a single interrupt target of a platform interrupt controller. Each cycle it looks at a vector of pending bits coming from the source gateways. It masks them with this target's own per-source enable bits. Among the survivors it picks the source with the largest priority value. It advertises that source's identifier together with a request line, but only when the winning priority is strictly above the target's threshold. Source bit `i` carries the identifier `i+1`, and the identifier 0 means that nothing is advertised. There is no global enable: a controller with several targets instantiates one copy of this block per target and shares the pending and priority vectors among the copies.

The block also holds the target's claim/complete port. A claim read returns the identifier advertised at the moment of the read. It also produces a one-cycle claim strobe on the matching source line, which the gateway uses to drop that source's pending bit. A completion write carries an identifier. A valid identifier produces a one-cycle completion strobe on the matching source line, so the gateway can accept new events again. Once the claimed source's pending bit falls, the selector moves on to the next-best candidate, or to a newly raised higher-priority one.

The port sequencer is a four-state machine. In `PS_IDLE` no strobe is driven. In `PS_CLAIM` the claim strobe is driven. In `PS_CMPL` the completion strobe is driven. In `PS_BOTH` both strobes are driven. From any state, the next state is chosen by two conditions. The first is an accepted claim, meaning a read while a non-zero identifier is advertised. The second is an accepted completion, meaning a write whose identifier lies between 1 and N. Neither condition leads to `PS_IDLE`. Only a claim leads to `PS_CLAIM`. Only a completion leads to `PS_CMPL`. Both together lead to `PS_BOTH`. Reset enters `PS_IDLE`.

Top module: `prio_tgt_sel`

## Requirements
- R1: Pending bit i maps to identifier i+1, so the advertised identifier lies in 1..N whenever the request is high and is 0 whenever it is low.
- R2: Among sources that are both pending and enabled, the one with the largest priority value is advertised.
- R3: When several candidates share the largest priority, the one with the lowest identifier is advertised.
- R4: The request is raised only when the winning priority is strictly greater than the threshold; a winner at or below the threshold gives request 0 and identifier 0.
- R5: A pending source whose enable bit is 0 is never advertised, and it does not hide a lower-priority enabled source.
- R6: During and after reset, the request, identifier, claim data and both strobes are 0.
- R7: The identifier and request are registered: they reflect the pending, enable, priority and threshold values sampled at the previous clock edge.
- R8: A claim read returns, one cycle later on the claim data output, the identifier advertised in the read cycle, and raises bit id-1 of the claim strobe for exactly that one cycle; the claim data holds until the next read.
- R9: A claim read while identifier 0 is advertised returns 0 and raises no claim strobe.
- R10: A completion write with an identifier in 1..N raises bit id-1 of the completion strobe for exactly the next cycle, independently of any claim in the same cycle.
- R11: A completion write with identifier 0 or greater than N raises no completion strobe.
- R12: After the claimed source's pending bit clears, the next-best candidate is advertised; a newly pending source of higher priority overrides it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_SRC | Pending bits from the gateways, bit i = source i+1 |
| en_i | input | N_SRC | This target's per-source enables |
| prio_i | input | N_SRC*PW | Packed priorities, source i at bits [i*PW +: PW] |
| thr_i | input | PW | This target's threshold |
| claim_rd_i | input | 1 | Claim read strobe |
| cmpl_wr_i | input | 1 | Completion write strobe |
| cmpl_id_i | input | IDW | Identifier carried by the completion write |
| irq_o | output | 1 | Interrupt request to the target |
| irq_id_o | output | IDW | Advertised identifier, 0 when none |
| claim_data_o | output | IDW | Value returned by the last claim read |
| claim_strb_o | output | N_SRC | One-cycle claim pulse per source |
| cmpl_strb_o | output | N_SRC | One-cycle completion pulse per source |

## Verification
The selector is first driven with a single pending source at the lowest and the highest bit position, which shows whether the bit-to-identifier mapping is off by one. Next come mixed priorities, which show whether the largest value is found, and then equal priorities across scattered bits, which show whether ties go to the lowest identifier rather than the highest. Threshold sweeps around the winning value separate a strict comparison from a non-strict one. Enable masking of the top candidate shows whether disabled sources leak into the search. Claim and completion sequences interleaved with pending-bit changes show the gateway hand-off, the handling of identifier 0 and of out-of-range completions, and the `PS_BOTH` path.

// File: rtl/prio_sel_pkg.sv
`timescale 1ns/1ps
package prio_sel_pkg;

    // Port sequencer states: which strobes are driven this cycle.
    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_CLAIM = 2'd1,
        PS_CMPL  = 2'd2,
        PS_BOTH  = 2'd3
    } port_st_e;

endpackage

// File: rtl/sel_mask.sv
`timescale 1ns/1ps
module sel_mask #(
    parameter int N_SRC = 8
) (
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] en_i,
    output logic [N_SRC-1:0] cand_o
);

    // Per-source qualification: pending and enabled for this target.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign cand_o[g] = pend_i[g] & en_i[g];
    end

endmodule

// File: rtl/sel_arb.sv
`timescale 1ns/1ps
module sel_arb #(
    parameter int N_SRC = 8,
    parameter int PW    = 3,
    parameter int IDW   = 4
) (
    input  logic [N_SRC-1:0]    cand_i,
    input  logic [N_SRC*PW-1:0] prio_i,
    output logic                best_vld_o,
    output logic [PW-1:0]       best_prio_o,
    output logic [IDW-1:0]      best_id_o
);

    logic [PW-1:0] pr [N_SRC];

    for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
        assign pr[g] = prio_i[g*PW +: PW];
    end

    // Ascending scan; a later source replaces the holder only when strictly
    // larger, so equal priorities keep the lower identifier.
    always_comb begin
        best_vld_o  = 1'b0;
        best_prio_o = '0;
        best_id_o   = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand_i[i] && (!best_vld_o || pr[i] > best_prio_o)) begin
                best_vld_o  = 1'b1;
                best_prio_o = pr[i];
                best_id_o   = IDW'(i + 1);
            end
        end
    end

endmodule

// File: rtl/sel_port.sv
`timescale 1ns/1ps
module sel_port
    import prio_sel_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDW   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             claim_rd_i,
    input  logic             cmpl_wr_i,
    input  logic [IDW-1:0]   cmpl_id_i,
    input  logic [IDW-1:0]   cur_id_i,
    output logic [IDW-1:0]   claim_data_o,
    output logic [N_SRC-1:0] claim_strb_o,
    output logic [N_SRC-1:0] cmpl_strb_o
);

    localparam logic [IDW-1:0] ID_MAX = IDW'(N_SRC);

    port_st_e       st_q, st_d;
    logic [IDW-1:0] clm_id_q, cpl_id_q, data_q;
    logic           claim_go, cmpl_go;

    assign claim_go = claim_rd_i && (cur_id_i != '0);
    assign cmpl_go  = cmpl_wr_i && (cmpl_id_i != '0) && (cmpl_id_i <= ID_MAX);

    always_comb begin
        unique case ({claim_go, cmpl_go})
            2'b00:   st_d = PS_IDLE;
            2'b10:   st_d = PS_CLAIM;
            2'b01:   st_d = PS_CMPL;
            default: st_d = PS_BOTH;
        endcase
    end

    // State register together with the identifiers the strobes decode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= PS_IDLE;
            clm_id_q <= '0;
            cpl_id_q <= '0;
            data_q   <= '0;
        end else begin
            st_q <= st_d;
            if (claim_go) clm_id_q <= cur_id_i;
            if (cmpl_go)  cpl_id_q <= cmpl_id_i;
            if (claim_rd_i) data_q <= cur_id_i;
        end
    end

    function automatic logic [N_SRC-1:0] id2vec(input logic [IDW-1:0] id);
        logic [N_SRC-1:0] v;
        for (int i = 0; i < N_SRC; i++) v[i] = (id == IDW'(i + 1));
        return v;
    endfunction

    always_comb begin
        claim_strb_o = '0;
        cmpl_strb_o  = '0;
        unique case (st_q)
            PS_IDLE:  ;
            PS_CLAIM: claim_strb_o = id2vec(clm_id_q);
            PS_CMPL:  cmpl_strb_o  = id2vec(cpl_id_q);
            PS_BOTH: begin
                claim_strb_o = id2vec(clm_id_q);
                cmpl_strb_o  = id2vec(cpl_id_q);
            end
            default: ;
        endcase
    end

    assign claim_data_o = data_q;

    assert_claim_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_strb_o));
    assert_cmpl_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmpl_strb_o));
    assert_claim_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        claim_rd_i |=> claim_data_o == $past(cur_id_i));
    assert_claim_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd_i && cur_id_i == '0) |=> claim_strb_o == '0);
    assert_cmpl_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_wr_i && (cmpl_id_i == '0 || cmpl_id_i > ID_MAX)) |=> cmpl_strb_o == '0);

endmodule

// File: rtl/prio_tgt_sel.sv
`timescale 1ns/1ps
module prio_tgt_sel #(
    parameter int N_SRC    = 8,
    parameter int PRIO_MAX = 7,
    parameter int PW       = $clog2(PRIO_MAX + 1),
    parameter int IDW      = $clog2(N_SRC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    pend_i,
    input  logic [N_SRC-1:0]    en_i,
    input  logic [N_SRC*PW-1:0] prio_i,
    input  logic [PW-1:0]       thr_i,
    input  logic                claim_rd_i,
    input  logic                cmpl_wr_i,
    input  logic [IDW-1:0]      cmpl_id_i,
    output logic                irq_o,
    output logic [IDW-1:0]      irq_id_o,
    output logic [IDW-1:0]      claim_data_o,
    output logic [N_SRC-1:0]    claim_strb_o,
    output logic [N_SRC-1:0]    cmpl_strb_o
);

    logic [N_SRC-1:0] cand;
    logic             best_vld;
    logic [PW-1:0]    best_prio;
    logic [IDW-1:0]   best_id;
    logic             win;
    logic             irq_q;
    logic [IDW-1:0]   id_q;

    sel_mask #(.N_SRC(N_SRC)) u_mask (
        .pend_i (pend_i),
        .en_i   (en_i),
        .cand_o (cand)
    );

    sel_arb #(.N_SRC(N_SRC), .PW(PW), .IDW(IDW)) u_arb (
        .cand_i      (cand),
        .prio_i      (prio_i),
        .best_vld_o  (best_vld),
        .best_prio_o (best_prio),
        .best_id_o   (best_id)
    );

    assign win = best_vld && (best_prio > thr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            id_q  <= '0;
        end else begin
            irq_q <= win;
            id_q  <= win ? best_id : '0;
        end
    end

    assign irq_o    = irq_q;
    assign irq_id_o = id_q;

    sel_port #(.N_SRC(N_SRC), .IDW(IDW)) u_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .claim_rd_i   (claim_rd_i),
        .cmpl_wr_i    (cmpl_wr_i),
        .cmpl_id_i    (cmpl_id_i),
        .cur_id_i     (id_q),
        .claim_data_o (claim_data_o),
        .claim_strb_o (claim_strb_o),
        .cmpl_strb_o  (cmpl_strb_o)
    );

    assert_id_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_id_o != '0 && irq_id_o <= IDW'(N_SRC)));
    assert_id_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> irq_id_o == '0);
    assert_above_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (PW'($past(prio_i) >> (PW * (int'(irq_id_o) - 1))) > $past(thr_i)));
    assert_win_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> |($past(pend_i & en_i) & (N_SRC'(1) << (int'(irq_id_o) - 1))));

endmodule

// File: tb/sim_prio_tgt_sel.sv
`timescale 1ns/1ps
module sim_prio_tgt_sel;

    localparam int N   = 8;
    localparam int PW  = 3;
    localparam int IDW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      pend_i = '0;
    logic [N-1:0]      en_i = '0;
    logic [N*PW-1:0]   prio_i;
    logic [PW-1:0]     thr_i = '0;
    logic              claim_rd_i = 1'b0;
    logic              cmpl_wr_i = 1'b0;
    logic [IDW-1:0]    cmpl_id_i = '0;
    logic              irq_o;
    logic [IDW-1:0]    irq_id_o;
    logic [IDW-1:0]    claim_data_o;
    logic [N-1:0]      claim_strb_o;
    logic [N-1:0]      cmpl_strb_o;
    logic [PW-1:0]     pr [N];

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) prio_i[i*PW +: PW] = pr[i];
    end

    prio_tgt_sel #(.N_SRC(N), .PRIO_MAX(7)) u0 (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .prio_i(prio_i),
        .thr_i(thr_i), .claim_rd_i(claim_rd_i), .cmpl_wr_i(cmpl_wr_i),
        .cmpl_id_i(cmpl_id_i), .irq_o(irq_o), .irq_id_o(irq_id_o),
        .claim_data_o(claim_data_o), .claim_strb_o(claim_strb_o),
        .cmpl_strb_o(cmpl_strb_o)
    );

    typedef struct {
        int    cyc;
        int    kind;
        int    val;
        string req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    exp_id = 0;
    int    exp_data = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int model();
        int best = 0;
        int bp = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i] && en_i[i] && int'(pr[i]) >= bp) begin
                best = i + 1;
                bp   = int'(pr[i]);
            end
        end
        if (best != 0 && bp > int'(thr_i)) return best;
        return 0;
    endfunction

    function automatic int actual(input int kind);
        case (kind)
            0: return int'(irq_id_o);
            1: return int'(irq_o);
            2: return int'(claim_data_o);
            3: return int'(claim_strb_o);
            default: return int'(cmpl_strb_o);
        endcase
    endfunction

    task automatic push(input int c, input int kind, input int val, input string req);
        item_t it;
        it.cyc = c; it.kind = kind; it.val = val; it.req = req;
        q.push_back(it);
    endtask

    // Driver: applies port strobes, predicts the next cycle's outputs.
    task automatic step(input bit clm, input bit cw, input int cid, input string tag);
        int nid;
        int cs;
        int ps;
        claim_rd_i = clm;
        cmpl_wr_i  = cw;
        cmpl_id_i  = IDW'(cid);
        nid = model();
        cs  = (clm && exp_id != 0) ? (1 << (exp_id - 1)) : 0;
        ps  = (cw && cid >= 1 && cid <= N) ? (1 << (cid - 1)) : 0;
        if (clm) exp_data = exp_id;
        push(cyc + 1, 0, nid, tag);
        push(cyc + 1, 1, (nid != 0) ? 1 : 0, tag);
        push(cyc + 1, 2, exp_data, tag);
        push(cyc + 1, 3, cs, tag);
        push(cyc + 1, 4, ps, tag);
        exp_id = nid;
        @(posedge clk);
        #5;
    endtask

    // Monitor: compares queued expectations at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            item_t it;
            int a;
            it = q.pop_front();
            a  = actual(it.kind);
            n_cmp++;
            if (a != it.val) begin
                n_bad++;
                $display("FAIL %s kind=%0d cycle=%0d actual=%0d expected=%0d",
                         it.req, it.kind, it.cyc, a, it.val);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) pr[i] = '0;
        repeat (3) @(posedge clk);
        #5;
        for (int k = 0; k < 5; k++) push(cyc, k, 0, "R6");
        @(posedge clk);
        #5;
        rst_n = 1'b1;
        step(0, 0, 0, "R6");
        step(0, 0, 0, "R6");

        // R5: pending but nothing enabled
        pend_i = '1;
        step(0, 0, 0, "R5");

        // R1 and R7: single source at bit 3, then at the top bit
        pend_i = 8'h08; en_i = '1; pr[3] = 3'd2;
        step(0, 0, 0, "R7");
        step(0, 0, 0, "R1");
        pend_i = 8'h80; pr[7] = 3'd1;
        step(0, 0, 0, "R1");
        pend_i = 8'h01; pr[0] = 3'd1;
        step(0, 0, 0, "R1");

        // R2: mixed priorities
        pr[0] = 3'd1; pr[1] = 3'd4; pr[2] = 3'd2; pr[3] = 3'd6;
        pr[4] = 3'd3; pr[5] = 3'd0; pr[6] = 3'd5; pr[7] = 3'd2;
        pend_i = '1;
        step(0, 0, 0, "R2");
        // R5: mask the top candidate
        en_i = 8'hF7;
        step(0, 0, 0, "R5");
        en_i = '1;

        // R3: ties
        for (int i = 0; i < N; i++) pr[i] = 3'd7;
        step(0, 0, 0, "R3");
        pend_i = 8'b1010_0100;
        step(0, 0, 0, "R3");

        // R4: threshold sweep
        pend_i = 8'h10; pr[4] = 3'd3; thr_i = 3'd3;
        step(0, 0, 0, "R4");
        thr_i = 3'd2;
        step(0, 0, 0, "R4");
        pr[4] = 3'd7; thr_i = 3'd7;
        step(0, 0, 0, "R4");
        pr[4] = 3'd0; thr_i = 3'd0;
        step(0, 0, 0, "R4");

        // R9: claim with nothing advertised
        pend_i = '0;
        step(0, 0, 0, "R9");
        step(1, 0, 0, "R9");
        step(0, 0, 0, "R9");

        // R8 / R12: claim, gateway clears, next best, higher arrival
        for (int i = 0; i < N; i++) pr[i] = 3'd0;
        pr[2] = 3'd5; pr[6] = 3'd3; pr[0] = 3'd6;
        pend_i = 8'b0100_0100;
        step(0, 0, 0, "R8");
        step(0, 0, 0, "R8");
        step(1, 0, 0, "R8");
        pend_i[2] = 1'b0;
        step(0, 0, 0, "R12");
        step(0, 0, 0, "R12");
        pend_i[0] = 1'b1;
        step(0, 0, 0, "R12");
        step(0, 0, 0, "R12");

        // R10: completion alone, then together with a claim
        step(0, 1, 3, "R10");
        step(0, 0, 0, "R10");
        step(1, 1, 8, "R10");
        pend_i[0] = 1'b0;
        step(0, 0, 0, "R10");

        // R11: out-of-range completions
        step(0, 1, 0, "R11");
        step(0, 1, 9, "R11");
        step(0, 1, 15, "R11");
        step(0, 0, 0, "R11");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule